// File: doc/BRIEF.md
# Programmable Pixel Clock Generator

This block turns a fast master clock into the pixel clock that goes out with a sensor's video data. It also produces two one-cycle strobes in the master-clock domain. The pixel enable marks the master cycle that opens each pixel-clock period, and downstream registers use it to launch frame valid, line valid and pixel data. The ADC enable is a slower strobe for the converter timing.

The pixel period is set in master-clock cycles by a 4-bit value, and a value of zero acts as one. A low-power flag doubles the period. The ADC strobe period stays at twice the programmed value in both power modes.

The output waveform can be inverted, or shifted later in half-master-cycle steps. The block reaches half-cycle resolution by choosing, from the level of the master clock, which of two registered half-phase streams drives the output. A new period, power mode, invert or delay setting is taken in only when a pixel period ends.

Top module: `pixclk_gen`

## Requirements
- R1: While `rst_n` is low, `pixclk`, `pix_en` and `adc_en` are all 0. After release, `pix_en` is high in the first full master cycle. The applied settings take over one cycle later, because the reset period is one cycle long. The reset state is also full power, not inverted, with a delay of 1.
- R2: In full power, `pix_en` is high for one master cycle out of every P cycles, where P is `period_cfg` (1 to 15).
- R3: A `period_cfg` of 0 gives the same timing as a value of 1.
- R4: With `low_power` high, the spacing of `pix_en` is 2·P master cycles.
- R5: With no inversion and zero delay, `pixclk` has the same period as `pix_en`. It is high from the start of the master cycle in which `pix_en` is high, for floor(P_eff/2) master cycles, and low for the rest of the period. When the effective period is 1, it is high in the first half of each master cycle and low in the second half.
- R6: With `invert_cfg` = 1, `pixclk` is the exact complement of the R5 waveform.
- R7: A `delay_cfg` of d (0 to 15) shifts the R5/R6 waveform later by d half master cycles.
- R8: `adc_en` is high only together with `pix_en`. Its pulses are spaced 2·P master cycles apart in both power modes, with P being `period_cfg` after the zero-to-one rule.
- R9: A change on `period_cfg`, `low_power`, `invert_cfg` or `delay_cfg` has no effect on the outputs until the current pixel period ends. From the next period on, the new setting applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_cfg | input | 4 | Pixel period in master cycles (0 acts as 1) |
| low_power | input | 1 | Doubles the pixel period |
| invert_cfg | input | 1 | Inverts the pixel clock |
| delay_cfg | input | 4 | Pixel clock delay in half master cycles |
| pixclk | output | 1 | Pixel clock waveform |
| pix_en | output | 1 | One-cycle strobe at the start of each pixel period |
| adc_en | output | 1 | One-cycle strobe every 2·period_cfg master cycles |

## Verification
Every period value, 0 through 15, is run in both power modes at zero delay and no inversion. This separates the odd and even duty-cycle rules, the one-cycle special case and the doubling.

A sweep over all 16 delays at a fixed odd period tells even delays from odd ones, which come from a different half-phase stream. Inverted runs and random settings mix the features together. For each setting the bench samples `pixclk` in both halves of every master cycle against a computed waveform, and it measures the spacing of both strobes.

A directed change made in the cycle where `pix_en` is high shows whether a new period and invert setting wait for the boundary.

// File: rtl/pixclk_gen.sv
`timescale 1ns/1ps
module pixclk_gen #(
  parameter int PW      = 4,
  parameter int DW      = 4,
  parameter int RST_PER = 1,
  parameter int RST_DLY = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_cfg,
  input  logic          low_power,
  input  logic          invert_cfg,
  input  logic [DW-1:0] delay_cfg,
  output logic          pixclk,
  output logic          pix_en,
  output logic          adc_en
);
  localparam int CW = PW + 1;
  localparam int NJ = 2 ** (DW - 1);

  logic [PW-1:0] per_a;
  logic          lp_a, inv_a, tg;
  logic [DW-1:0] dly_a;
  logic [CW-1:0] cnt, pe, half;
  logic [NJ-1:1] s1;
  logic [NJ:1]   s2;
  logic [NJ-1:0] w1;
  logic [NJ:0]   w2;
  logic [DW-2:0] j;
  logic [DW-1:0] jp;
  logic          p1, last, hi, b1, b2, raw;

  assign pe   = lp_a ? {per_a, 1'b0} : {1'b0, per_a};
  assign half = pe >> 1;
  assign p1   = (pe == CW'(1));
  assign last = (cnt == pe - 1'b1);
  assign hi   = cnt < half;
  assign b1   = rst_n & (p1 | hi);
  assign b2   = rst_n & ~p1 & hi;

  assign pix_en = rst_n & (cnt == '0);
  assign adc_en = pix_en & (lp_a | ~tg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      per_a <= PW'(RST_PER);
      lp_a  <= 1'b0;
      inv_a <= 1'b0;
      dly_a <= DW'(RST_DLY);
      tg    <= 1'b0;
      s1    <= '0;
      s2    <= '0;
    end else begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (last) begin
        per_a <= (period_cfg == '0) ? PW'(1) : period_cfg;
        lp_a  <= low_power;
        inv_a <= invert_cfg;
        dly_a <= delay_cfg;
      end
      if (pix_en) tg <= ~tg;
      s1 <= {s1[NJ-2:1], b1};
      s2 <= {s2[NJ-1:1], b2};
    end
  end

  assign w1  = {s1, b1};
  assign w2  = {s2, b2};
  assign j   = dly_a[DW-1:1];
  assign jp  = {1'b0, j} + 1'b1;
  assign raw = clk ? (dly_a[0] ? w2[jp] : w1[j])
                   : (dly_a[0] ? w1[j]  : w2[j]);
  assign pixclk = inv_a ^ raw;

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(per_a) && $stable(lp_a) && $stable(inv_a) && $stable(dly_a)));
  // R3
  per_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_a != '0);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < pe);
  // R2
  pix_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !p1) |=> !pix_en);
  // R8
  adc_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !lp_a && last && adc_en) |=> !adc_en);
endmodule

// File: tb/pixclk_gen_bench.sv
`timescale 1ns/1ps
module pixclk_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] period_cfg = 4'd6, delay_cfg = 4'd0;
  logic low_power = 1'b0, invert_cfg = 1'b0;
  logic pixclk, pix_en, adc_en;
  int checks = 0, fails = 0;
  logic f_clk1, f_clk2, f_pix, f_adc;

  always #2 clk = ~clk;

  pixclk_gen u_pixclk_gen (.clk(clk), .rst_n(rst_n), .period_cfg(period_cfg),
    .low_power(low_power), .invert_cfg(invert_cfg), .delay_cfg(delay_cfg),
    .pixclk(pixclk), .pix_en(pix_en), .adc_en(adc_en));

  task automatic cyc();
    @(posedge clk); #1;
    f_clk1 = pixclk; f_pix = pix_en; f_adc = adc_en;
    #2;
    f_clk2 = pixclk;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit hi_at(int p, int q);
    if (p == 1) return q == 0;
    return (q / 2) < (p / 2);
  endfunction

  function automatic bit exp_clk(int p, bit inv, int d, int o);
    int q;
    q = ((o - d) % (2 * p) + 2 * p) % (2 * p);
    return inv ^ hi_at(p, q);
  endfunction

  task automatic measure(int pn, bit lp, bit inv, int d);
    int p, pnn, guard, mism, act, expv, lastpix, lastadc, badpix, badadc;
    string rw, rp;
    period_cfg = 4'(pn); low_power = lp; invert_cfg = inv; delay_cfg = 4'(d);
    pnn = (pn == 0) ? 1 : pn;
    p = pnn << lp;
    repeat (48) cyc();
    guard = 0;
    do begin cyc(); guard++; end while (!f_pix && guard < 64);
    mism = 0; act = 0; expv = 0; lastpix = 0; lastadc = -1; badpix = -1; badadc = -1;
    for (int c = 0; c < 64; c++) begin
      if (c > 0) begin
        cyc();
        if (f_pix) begin
          if (c - lastpix != p && badpix < 0) badpix = c - lastpix;
          lastpix = c;
        end
      end
      if (f_adc) begin
        if (lastadc >= 0 && c - lastadc != 2 * pnn && badadc < 0) badadc = c - lastadc;
        lastadc = c;
      end
      if (f_clk1 != exp_clk(p, inv, d, 2 * c)) begin
        if (mism == 0) begin act = f_clk1; expv = exp_clk(p, inv, d, 2 * c); end
        mism++;
      end
      if (f_clk2 != exp_clk(p, inv, d, 2 * c + 1)) begin
        if (mism == 0) begin act = f_clk2; expv = exp_clk(p, inv, d, 2 * c + 1); end
        mism++;
      end
    end
    rw = (d != 0) ? "R7" : (inv ? "R6" : "R5");
    rp = lp ? "R4" : ((pn == 0) ? "R3" : "R2");
    chk(mism == 0 && guard < 64, rw, act, expv);
    chk(badpix < 0, rp, badpix, p);
    chk(badadc < 0 && lastadc >= 0, "R8", badadc, 2 * pnn);
  endtask

  initial begin
    #600000;
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c;
    bit okk;
    void'($urandom(32'd4242));
    repeat (3) cyc();
    // R1: reset state
    chk(f_clk1 == 0 && f_clk2 == 0, "R1", f_clk1 | f_clk2, 0);
    chk(f_pix == 0 && f_adc == 0, "R1", f_pix | f_adc, 0);
    rst_n = 1'b1;
    cyc();
    chk(f_pix == 1, "R1", f_pix, 1);
    c = 0;
    do begin cyc(); c++; end while (!f_pix && c < 40);
    chk(c == 6, "R1", c, 6);

    for (int lp = 0; lp < 2; lp++)
      for (int pn = 0; pn < 16; pn++) measure(pn, lp[0], 1'b0, 0);
    for (int d = 0; d < 16; d++) measure(5, 1'b0, 1'b0, d);
    measure(4, 1'b0, 1'b1, 0);
    measure(7, 1'b1, 1'b1, 3);
    measure(1, 1'b0, 1'b1, 1);
    measure(0, 1'b1, 1'b1, 0);
    for (int k = 0; k < 30; k++)
      measure(int'($urandom() % 16), 1'($urandom()), 1'($urandom()), int'($urandom() % 16));

    // R9: change settings in the pix_en cycle of a 12-cycle period
    measure(12, 1'b0, 1'b0, 0);
    c = 0;
    do begin cyc(); c++; end while (!f_pix && c < 40);
    period_cfg = 4'd3; invert_cfg = 1'b1;
    cyc();
    chk(f_clk1 == 1, "R9", f_clk1, 1);
    c = 1;
    okk = 1;
    while (c < 40) begin
      cyc(); c++;
      if (f_pix) break;
    end
    chk(c == 12, "R9", c, 12);
    chk(f_clk1 == 0, "R9", f_clk1, 0);
    c = 0;
    do begin cyc(); c++; end while (!f_pix && c < 40);
    chk(c == 3 && okk, "R9", c, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule